// File: doc/BRIEF.md
# MSB-Aligned Pixel Component Mapper

This block packs colour components into fixed 48-bit pixel words. Each pixel word has three 16-bit lanes. Every component is aligned to the most significant end of its lane, and the bits below it are zeroed. The word layout depends on the colour format and the bits-per-component depth. Both are run-time inputs, and the block checks that the pair is legal.

A beat carries `PPC` pixels side by side. Each pixel has its own keep bit. For 4:2:2 material the block labels every kept pixel as Cr or Cb. The label alternates in pixel order within a beat and across beats. A line-start or frame-start marker on a beat restarts the sequence at Cr.

The input and output are valid/ready streams with one register stage between them. An output beat that has not been accepted stays unchanged. The upstream side may present a new beat whenever the output register is empty or is being drained in the same cycle.

Top module: `pmap_top`

## Requirements
- R1: With format code 0 (RGB) or 1 (YCbCr 4:4:4), component A of each pixel goes to word bits 47:32, component B to bits 31:16 and component C to bits 15:0. Each component is aligned to the top of its lane.
- R2: Depth code 0/1/2/3/4 selects 6/8/10/12/16 bits per component. A component of w bits takes the top w bits of its lane. The lower 16-w bits are zero, and input bits at position w or above are ignored.
- R3: Format codes 0 and 1 accept depth codes 0..4. Format codes 2 (4:2:2) and 3 (luma-only) accept depth codes 1..4. Depth codes 5..7 are unsupported with every format.
- R4: With format code 2, component A (chroma) goes to bits 47:32, component B (luma) goes to bits 31:16, and bits 15:0 are zero.
- R5: With format code 3, component B (luma) goes to bits 47:32, and bits 31:0 are zero.
- R6: For supported 4:2:2 beats, `out_cb[i]` is 1 for a Cb pixel and 0 for a Cr pixel. The label toggles for each kept pixel in index order, continuing across accepted beats. Non-4:2:2 beats carry `out_cb` = 0 and leave the sequence unchanged.
- R7: An accepted beat with `in_sol` or `in_sof` set restarts the sequence, so its first kept 4:2:2 pixel is Cr.
- R8: For an unsupported format/depth pair, `out_err` is 1, all output words are zero, `out_cb` is zero, and the sequence does not advance.
- R9: A pixel whose keep bit is 0 outputs a zero word and `out_cb` 0, and does not advance the sequence.
- R10: An accepted beat appears at the output on the next clock. `in_ready` is high when the output is empty or `out_ready` is high. A held output beat stays stable until it is taken.
- R11: During and after reset, `out_valid` is 0 and the sequence starts at Cr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Format code: 0 RGB, 1 YCbCr 4:4:4, 2 YCbCr 4:2:2, 3 luma-only |
| cfg_depth | input | 3 | Depth code: 0..4 = 6, 8, 10, 12, 16 bits |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_keep | input | PPC | Per-pixel valid |
| in_sol | input | 1 | Beat begins a line |
| in_sof | input | 1 | Beat begins a frame |
| in_comp_a | input | PPC*16 | Component A per pixel, right-aligned |
| in_comp_b | input | PPC*16 | Component B per pixel, right-aligned |
| in_comp_c | input | PPC*16 | Component C per pixel, right-aligned |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_word | output | PPC*48 | Packed pixel words, pixel 0 in the low 48 bits |
| out_keep | output | PPC | Per-pixel valid, passed through |
| out_cb | output | PPC | 4:2:2 chroma label, 1 = Cb |
| out_err | output | 1 | Unsupported format/depth on this beat |

## Verification
The phase restart and the phase advance can fall on the same beat. The bench provokes this by raising a line or frame marker on a 4:2:2 beat where several pixels are kept. The first kept pixel must read Cr and the next must read Cb, and the sequence then continues from there. Acceptance of a new beat and draining of the held one can also coincide. Random `out_ready` stalls force beats to be taken in the same cycle the output empties. A behavioural queue model predicts every word and label, and each accepted beat is compared in order.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int LANE_W = 16;
  localparam int LANES  = 3;
  localparam int WORD_W = LANE_W * LANES;
  localparam int SH_W   = $clog2(LANE_W) + 1;

  typedef enum logic [1:0] {
    FMT_RGB    = 2'd0,
    FMT_YCC444 = 2'd1,
    FMT_YCC422 = 2'd2,
    FMT_YONLY  = 2'd3
  } pmap_fmt_e;

  // depth code to component width
  function automatic logic [SH_W-1:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd0:    depth_bits = SH_W'(6);
      3'd1:    depth_bits = SH_W'(8);
      3'd2:    depth_bits = SH_W'(10);
      3'd3:    depth_bits = SH_W'(12);
      default: depth_bits = SH_W'(16);
    endcase
  endfunction

  // legality of a format/depth pair
  function automatic logic combo_ok(input pmap_fmt_e fmt, input logic [2:0] code);
    if (code > 3'd4) return 1'b0;
    if (code == 3'd0 && (fmt == FMT_YCC422 || fmt == FMT_YONLY)) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/pmap_align.sv
module pmap_align
  import pmap_pkg::*;
(
  input  logic [LANE_W-1:0] val,
  input  logic [SH_W-1:0]   width,
  output logic [LANE_W-1:0] aligned
);
  logic [SH_W-1:0] shift;

  // shifting left discards bits above the component width
  // and leaves zeros below it
  always_comb begin
    shift   = SH_W'(LANE_W) - width;
    aligned = val << shift;
  end
endmodule

// File: rtl/pmap_pixel.sv
module pmap_pixel
  import pmap_pkg::*;
(
  input  logic [LANE_W-1:0] comp_a,
  input  logic [LANE_W-1:0] comp_b,
  input  logic [LANE_W-1:0] comp_c,
  input  pmap_fmt_e         fmt,
  input  logic [SH_W-1:0]   width,
  input  logic              keep,
  input  logic              ok,
  output logic [WORD_W-1:0] word
);
  logic [LANE_W-1:0] al [LANES];
  logic [LANE_W-1:0] src [LANES];

  always_comb begin
    src[0] = comp_a;
    src[1] = comp_b;
    src[2] = comp_c;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pmap_align u_align (
      .val     (src[l]),
      .width   (width),
      .aligned (al[l])
    );
  end

  always_comb begin
    word = '0;
    if (keep && ok) begin
      unique case (fmt)
        FMT_RGB, FMT_YCC444: word = {al[0], al[1], al[2]};
        FMT_YCC422:          word = {al[0], al[1], {LANE_W{1'b0}}};
        FMT_YONLY:           word = {al[1], {2*LANE_W{1'b0}}};
        default:             word = '0;
      endcase
    end
  end
endmodule

// File: rtl/pmap_phase.sv
module pmap_phase #(
  parameter int PPC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           restart,
  input  logic           advance,
  input  logic [PPC-1:0] keep,
  output logic [PPC-1:0] label
);
  logic phase_q;
  logic phase_d;
  logic run;

  always_comb begin
    run   = restart ? 1'b0 : phase_q;
    label = '0;
    for (int i = 0; i < PPC; i++) begin
      if (keep[i] && advance) begin
        label[i] = run;
        run      = ~run;
      end
    end
    phase_d = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= 1'b0;
    else if (fire) phase_q <= phase_d;
  end
endmodule

// File: rtl/pmap_top.sv
module pmap_top
  import pmap_pkg::*;
#(
  parameter int PPC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_fmt,
  input  logic [2:0]            cfg_depth,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [PPC-1:0]        in_keep,
  input  logic                  in_sol,
  input  logic                  in_sof,
  input  logic [PPC*16-1:0]     in_comp_a,
  input  logic [PPC*16-1:0]     in_comp_b,
  input  logic [PPC*16-1:0]     in_comp_c,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [PPC*48-1:0]     out_word,
  output logic [PPC-1:0]        out_keep,
  output logic [PPC-1:0]        out_cb,
  output logic                  out_err
);
  localparam int BUS_W = PPC * WORD_W;

  pmap_fmt_e         fmt;
  logic [SH_W-1:0]   width;
  logic              ok;
  logic              fire;
  logic [PPC-1:0]    label;
  logic [BUS_W-1:0]  word_d;

  always_comb begin
    fmt      = pmap_fmt_e'(cfg_fmt);
    width    = depth_bits(cfg_depth);
    ok       = combo_ok(fmt, cfg_depth);
    in_ready = !out_valid || out_ready;
    fire     = in_valid && in_ready;
  end

  for (genvar p = 0; p < PPC; p++) begin : g_pix
    pmap_pixel u_pix (
      .comp_a (in_comp_a[p*LANE_W +: LANE_W]),
      .comp_b (in_comp_b[p*LANE_W +: LANE_W]),
      .comp_c (in_comp_c[p*LANE_W +: LANE_W]),
      .fmt    (fmt),
      .width  (width),
      .keep   (in_keep[p]),
      .ok     (ok),
      .word   (word_d[p*WORD_W +: WORD_W])
    );
  end

  pmap_phase #(.PPC(PPC)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .restart (in_sol || in_sof),
    .advance (ok && fmt == FMT_YCC422),
    .keep    (in_keep),
    .label   (label)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_keep  <= '0;
      out_cb    <= '0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= word_d;
        out_keep <= in_keep;
        out_cb   <= label;
        out_err  <= !ok;
      end
    end
  end
endmodule

// File: rtl/pmap_checker.sv
module pmap_checker #(
  parameter int PPC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PPC*48-1:0] out_word,
  input logic [PPC-1:0]    out_keep,
  input logic [PPC-1:0]    out_cb,
  input logic              out_err
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_cb) && $stable(out_err)); // R10

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R10

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_word == '0 && out_cb == '0); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !out_valid); // R11

  for (genvar i = 0; i < PPC; i++) begin : g_pix
    AST_DROPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_keep[i] |-> out_word[i*48 +: 48] == '0 && !out_cb[i]); // R9

    AST_CB_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_cb[i] |-> out_word[i*48 +: 16] == '0); // R4
  end
endmodule

bind pmap_top pmap_checker #(.PPC(PPC)) u_pmap_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_keep  (out_keep),
  .out_cb    (out_cb),
  .out_err   (out_err)
);

// File: tb/pmap_top_tb_top.sv
`timescale 1ns/1ps
module pmap_top_tb_top;
  localparam int PPC = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_fmt = '0;
  logic [2:0]        cfg_depth = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [PPC-1:0]    in_keep = '0;
  logic              in_sol = 1'b0;
  logic              in_sof = 1'b0;
  logic [PPC*16-1:0] in_comp_a = '0;
  logic [PPC*16-1:0] in_comp_b = '0;
  logic [PPC*16-1:0] in_comp_c = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [PPC*48-1:0] out_word;
  logic [PPC-1:0]    out_keep;
  logic [PPC-1:0]    out_cb;
  logic              out_err;

  int checks = 0;
  int failures = 0;
  int ready_pct = 100;
  bit done = 1'b0;
  int ph = 0;

  logic [PPC*48-1:0] q_word[$];
  logic [PPC-1:0]    q_cb[$];
  logic              q_err[$];

  always #4 clk = ~clk;

  pmap_top #(.PPC(PPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_depth(cfg_depth),
    .in_valid(in_valid), .in_ready(in_ready), .in_keep(in_keep),
    .in_sol(in_sol), .in_sof(in_sof), .in_comp_a(in_comp_a),
    .in_comp_b(in_comp_b), .in_comp_c(in_comp_c), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_keep(out_keep),
    .out_cb(out_cb), .out_err(out_err)
  );

  function automatic int wbits(input int code);
    case (code)
      0: return 6;
      1: return 8;
      2: return 10;
      3: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic logic [15:0] top_align(input logic [15:0] v, input int w);
    int m;
    m = int'(v) % (1 << w);
    return 16'(m * (1 << (16 - w)));
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: computes one expected beat from the inputs being accepted
  task automatic model_accept();
    int f, c, w;
    bit good;
    logic [PPC*48-1:0] wd;
    logic [PPC-1:0] cb;
    logic [15:0] a, b, cc;
    f = int'(cfg_fmt);
    c = int'(cfg_depth);
    w = wbits(c);
    good = (c <= 4) && !(c == 0 && (f == 2 || f == 3));
    wd = '0;
    cb = '0;
    if (in_sol || in_sof) ph = 0;                                  // R7
    for (int i = 0; i < PPC; i++) begin
      a  = in_comp_a[i*16 +: 16];
      b  = in_comp_b[i*16 +: 16];
      cc = in_comp_c[i*16 +: 16];
      if (in_keep[i] && good) begin
        if (f <= 1)      wd[i*48 +: 48] = {top_align(a, w), top_align(b, w), top_align(cc, w)};
        else if (f == 2) wd[i*48 +: 48] = {top_align(a, w), top_align(b, w), 16'h0};
        else             wd[i*48 +: 48] = {top_align(b, w), 32'h0};
        if (f == 2) begin
          cb[i] = ph[0];
          ph = 1 - ph;
        end
      end
    end
    q_word.push_back(wd);
    q_cb.push_back(cb);
    q_err.push_back(!good);
  endtask

  // monitor at the falling edge: compare, then record the accepted beat
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == (q_word.size() != 0), "R10", "out_valid", 128'(out_valid), 128'(q_word.size() != 0));
      if (out_valid && out_ready && q_word.size() != 0) begin
        logic [PPC*48-1:0] ew;
        logic [PPC-1:0] ec;
        logic ee;
        ew = q_word.pop_front();
        ec = q_cb.pop_front();
        ee = q_err.pop_front();
        check(out_word == ew, "R1/R2/R4/R5/R9", "word", 128'(out_word), 128'(ew));
        check(out_cb == ec, "R6/R7", "chroma label", 128'(out_cb), 128'(ec));
        check(out_err == ee, "R3/R8", "error flag", 128'(out_err), 128'(ee));
      end
      if (in_valid && in_ready) model_accept();
    end
  end

  always @(posedge clk) begin
    #1 out_ready = ($urandom_range(99) < ready_pct);
  end

  task automatic send(input int f, input int c, input logic [PPC-1:0] k,
                      input bit sol, input bit sof);
    cfg_fmt   = 2'(f);
    cfg_depth = 3'(c);
    in_keep   = k;
    in_sol    = sol;
    in_sof    = sof;
    for (int i = 0; i < PPC; i++) begin
      in_comp_a[i*16 +: 16] = 16'($urandom);
      in_comp_b[i*16 +: 16] = 16'($urandom);
      in_comp_c[i*16 +: 16] = 16'($urandom);
    end
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #2 in_valid = 1'b0;
    in_sol = 1'b0;
    in_sof = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0, "R11", "out_valid in reset", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready after reset", 128'(in_ready), 128'(1));
    @(posedge clk);
    #2;
    // R11: first 4:2:2 pixel after reset with no marker is Cr
    send(2, 1, 2'b11, 1'b0, 1'b0);
    // R6 R7: restart and advance on the same beat, across patterns
    for (int f = 0; f < 4; f++) begin
      for (int c = 0; c < 8; c++) begin
        for (int n = 0; n < 6; n++) begin
          send(f, c, 2'($urandom), n == 0 || $urandom_range(3) == 0, n == 0 && c == 0);
          if ($urandom_range(2) == 0) begin @(posedge clk); #2; end
        end
      end
    end
    // R8: error beat between 4:2:2 beats leaves the sequence
    send(2, 2, 2'b01, 1'b1, 1'b0);
    send(3, 0, 2'b11, 1'b0, 1'b0);
    send(2, 2, 2'b11, 1'b0, 1'b0);
    // R10: back-pressure stretches
    ready_pct = 30;
    for (int n = 0; n < 200; n++) begin
      send(int'($urandom_range(3)), int'($urandom_range(4)), 2'($urandom),
           $urandom_range(4) == 0, $urandom_range(15) == 0);
    end
    ready_pct = 0;
    send(2, 4, 2'b11, 1'b0, 1'b1);
    repeat (5) @(posedge clk);
    ready_pct = 100;
    for (int n = 0; n < 100; n++) begin
      send(2, int'($urandom_range(4, 1)), 2'($urandom), $urandom_range(5) == 0, 1'b0);
    end
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(q_word.size() == 0, "R10", "beats drained", 128'(q_word.size()), 128'(0));
    done = 1'b1;
    finish_run();
  end
endmodule